// File: doc/BRIEF.md
# Protected Address Range Register Pair

This block holds one programmable memory-protection window. The window is described by a low-bound register and a high-bound register. Software reaches both through a small register bus. Every write on that bus carries two attributes of the requester: whether it runs at supervisor level, and whether it is a secure agent. A write changes a register only when the requester is a supervisor and one more condition holds: either the companion permission logic drives the `nonsecure_ok` input high, or the requester is secure. Any other write is dropped, and a one-cycle error pulse answers it.

Addresses are kept at page granularity. The page size is 1 KB by default and can be set to 64 KB by a parameter. Only the bits above the page offset are stored. On a read, the low bound returns zeros below the page boundary and the high bound returns ones there, so the high bound covers every byte of its last page. The block also checks a transaction address against the full 32-bit bounds and raises a hit flag while the address lies inside the window.

Top module: `prot_range_pair`

## Requirements
- R1: After reset the low bound reads 0x0000_0000 and the high bound reads all ones below the page boundary with zeros above it (0x0000_03FF for 1 KB pages), so the window covers only page 0.
- R2: A write with `req_supervisor` low changes neither register.
- R3: When `nonsecure_ok` is 0, a supervisor write also needs `req_secure` high to take effect; without it the write changes nothing.
- R4: When `nonsecure_ok` is 1, any supervisor write takes effect, whatever the value of `req_secure`.
- R5: A read of the low bound (`reg_sel` = 0) returns the stored field in bits 31:PAGE_BITS and zeros in bits PAGE_BITS-1:0, whatever was written to those low bits.
- R6: A read of the high bound (`reg_sel` = 1) returns the stored field in bits 31:PAGE_BITS and ones in bits PAGE_BITS-1:0, whatever was written to those low bits.
- R7: `reg_werr` is high for exactly the one cycle after a rejected write and stays low after accepted writes and idle cycles.
- R8: `txn_hit` is high exactly when `txn_addr` is at or above the full low bound and at or below the full high bound, comparing all 32 bits. The output is combinational from the stored bounds.
- R9: Read data is registered. A read strobe at one clock edge puts the selected register on `reg_rdata` from that edge on, and the value holds until the next read strobe.
- R10: With PAGE_BITS = 16 (64 KB pages), only bits 31:16 are stored, and bits 15:0 read as 0 for the low bound and as 0xFFFF for the high bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_rd_en | input | 1 | Read strobe |
| reg_sel | input | 1 | Register select: 0 low bound, 1 high bound |
| reg_wdata | input | 32 | Write data |
| req_supervisor | input | 1 | Requester runs at supervisor level |
| req_secure | input | 1 | Requester is a secure agent |
| nonsecure_ok | input | 1 | From the permission logic: 1 lets non-secure supervisors write |
| reg_rdata | output | 32 | Registered read data |
| reg_werr | output | 1 | One-cycle pulse after a rejected write |
| txn_addr | input | 32 | Transaction address to classify |
| txn_hit | output | 1 | Address lies within the window |

## Verification
The bench tries a write with every combination of supervisor level, security and the `nonsecure_ok` flag, to each of the two registers. The write data always has nonzero page-offset bits. The combinations show where the acceptance rule splits: user writes are dropped, secure supervisors are always accepted, and non-secure supervisors are accepted only when the flag allows it. The nonzero offset bits show that the read fill comes from the register and not from the write data. After every write the window is probed one below the low bound, at the low bound, in the middle, at the high bound and one above it, which tells an inclusive comparison from an exclusive or off-by-one one. A second instance with 64 KB pages repeats the reset values, the stored data and the boundary probes with the wider offset.

// File: rtl/prot_range_pkg.sv
package prot_range_pkg;

    localparam int ADDR_W = 32;

    typedef enum logic {
        SEL_LOW  = 1'b0,
        SEL_HIGH = 1'b1
    } bound_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        bound_sel_e        sel;
        logic              sup;
        logic              sec;
        logic [ADDR_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } window_t;

    // Supervisor is always required; secure is required unless the
    // permission logic opens the range to non-secure supervisors.
    function automatic logic write_allowed(input logic sup,
                                           input logic sec,
                                           input logic ns_ok);
        return sup && (ns_ok || sec);
    endfunction

endpackage

// File: rtl/prot_range_wgate.sv
module prot_range_wgate
    import prot_range_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  bound_sel_e sel,
    input  logic       sup,
    input  logic       sec,
    input  logic       ns_ok,
    output logic [1:0] we,
    output logic       werr
);

    logic ok;
    logic werr_q;

    assign ok    = write_allowed(sup, sec, ns_ok);
    assign we[0] = wr && ok && (sel == SEL_LOW);
    assign we[1] = wr && ok && (sel == SEL_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            werr_q <= 1'b0;
        end else begin
            werr_q <= wr && !ok;
        end
    end

    assign werr = werr_q;

endmodule

// File: rtl/prot_range_field.sv
module prot_range_field #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 10,
    parameter bit FILL_ONES = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [ADDR_W-PAGE_BITS-1:0] wfield,
    output logic [ADDR_W-1:0]        full
);

    localparam int FIELD_W = ADDR_W - PAGE_BITS;

    logic [FIELD_W-1:0] field_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= '0;
        end else if (we) begin
            field_q <= wfield;
        end
    end

    generate
        if (FILL_ONES) begin : g_fill_ones
            assign full = {field_q, {PAGE_BITS{1'b1}}};
        end else begin : g_fill_zeros
            assign full = {field_q, {PAGE_BITS{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/prot_range_cmp.sv
module prot_range_cmp
    import prot_range_pkg::*;
(
    input  window_t           win,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic above_lo;
    logic below_hi;

    assign above_lo = (addr >= win.lo);
    assign below_hi = (addr <= win.hi);
    assign hit      = above_lo && below_hi;

endmodule

// File: rtl/prot_range_pair.sv
module prot_range_pair
    import prot_range_pkg::*;
#(
    parameter int PAGE_BITS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic              reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              req_supervisor,
    input  logic              req_secure,
    input  logic              nonsecure_ok,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              reg_werr,
    input  logic [ADDR_W-1:0] txn_addr,
    output logic              txn_hit
);

    localparam int FIELD_W = ADDR_W - PAGE_BITS;

    bus_req_t          req;
    logic [1:0]        we;
    logic [ADDR_W-1:0] bound_full [2];
    logic [ADDR_W-1:0] rdata_q;
    window_t           win;
    logic              wdata_low_unused;

    assign req.wr    = reg_wr_en;
    assign req.rd    = reg_rd_en;
    assign req.sel   = bound_sel_e'(reg_sel);
    assign req.sup   = req_supervisor;
    assign req.sec   = req_secure;
    assign req.wdata = reg_wdata;

    assign wdata_low_unused = ^req.wdata[PAGE_BITS-1:0];

    prot_range_wgate u_wgate (
        .clk   (clk),
        .rst   (rst),
        .wr    (req.wr),
        .sel   (req.sel),
        .sup   (req.sup),
        .sec   (req.sec),
        .ns_ok (nonsecure_ok),
        .we    (we),
        .werr  (reg_werr)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bound
        prot_range_field #(
            .ADDR_W    (ADDR_W),
            .PAGE_BITS (PAGE_BITS),
            .FILL_ONES (b == 1)
        ) u_field (
            .clk    (clk),
            .rst    (rst),
            .we     (we[b]),
            .wfield (req.wdata[ADDR_W-1:PAGE_BITS]),
            .full   (bound_full[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (req.rd) begin
            rdata_q <= (req.sel == SEL_HIGH) ? bound_full[1] : bound_full[0];
        end
    end

    assign reg_rdata = rdata_q;

    assign win.lo = bound_full[0];
    assign win.hi = bound_full[1];

    prot_range_cmp u_cmp (
        .win  (win),
        .addr (txn_addr),
        .hit  (txn_hit)
    );

endmodule

// File: rtl/prot_range_pair_chk.sv
module prot_range_pair_chk #(
    parameter int PAGE_BITS = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        wr,
    input logic        rd,
    input logic        sel,
    input logic        sup,
    input logic        sec,
    input logic        ns_ok,
    input logic [31:0] rdata,
    input logic        werr,
    input logic [31:0] addr,
    input logic        hit,
    input logic [31:0] lo,
    input logic [31:0] hi
);

    AST_USER_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr && !sup) |=> ($stable(lo) && $stable(hi) && werr)); // R2

    AST_INSECURE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr && sup && !sec && !ns_ok) |=> ($stable(lo) && $stable(hi) && werr)); // R3

    AST_NS_SUP_WRITE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (wr && sup && ns_ok) |=> !werr); // R4

    AST_LOW_READ_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (rd && !sel) |=> (rdata[PAGE_BITS-1:0] == '0)); // R5

    AST_HIGH_READ_ONE_FILL: assert property (@(posedge clk) disable iff (rst)
        (rd && sel) |=> (rdata[PAGE_BITS-1:0] == '1)); // R6

    AST_WERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        werr |-> $past(wr)); // R7

    AST_MISS_ABOVE_LOW_IS_PAST_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!hit && addr >= lo) |-> (addr > hi)); // R8

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata)); // R9

endmodule

bind prot_range_pair prot_range_pair_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr_en),
    .rd    (reg_rd_en),
    .sel   (reg_sel),
    .sup   (req_supervisor),
    .sec   (req_secure),
    .ns_ok (nonsecure_ok),
    .rdata (reg_rdata),
    .werr  (reg_werr),
    .addr  (txn_addr),
    .hit   (txn_hit),
    .lo    (win.lo),
    .hi    (win.hi)
);

// File: tb/test_prot_range_pair.sv
module test_prot_range_pair;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, sel = 1'b0;
    logic [31:0] wdata = '0;
    logic        sup = 1'b0, sec = 1'b0, ns_ok = 1'b0;
    logic [31:0] rdata;
    logic        werr;
    logic [31:0] taddr = '0;
    logic        hit;

    logic        w_wr_en = 1'b0, w_rd_en = 1'b0, w_sel = 1'b0;
    logic [31:0] w_wdata = '0;
    logic [31:0] w_rdata;
    logic        w_werr;
    logic [31:0] w_taddr = '0;
    logic        w_hit;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_lo, exp_hi;

    always #10 clk = ~clk;

    prot_range_pair #(.PAGE_BITS(10)) i_prot_range_pair (
        .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
        .reg_sel(sel), .reg_wdata(wdata), .req_supervisor(sup),
        .req_secure(sec), .nonsecure_ok(ns_ok), .reg_rdata(rdata),
        .reg_werr(werr), .txn_addr(taddr), .txn_hit(hit)
    );

    prot_range_pair #(.PAGE_BITS(16)) i_prot_range_pair_wide (
        .clk(clk), .rst(rst), .reg_wr_en(w_wr_en), .reg_rd_en(w_rd_en),
        .reg_sel(w_sel), .reg_wdata(w_wdata), .req_supervisor(1'b1),
        .req_secure(1'b1), .nonsecure_ok(1'b0), .reg_rdata(w_rdata),
        .reg_werr(w_werr), .txn_addr(w_taddr), .txn_hit(w_hit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic do_write(input logic s, input logic [31:0] d, input logic p,
                            input logic c, input logic n, output logic err_seen,
                            output logic err_after);
        @(negedge clk);
        wr_en = 1'b1; sel = s; wdata = d; sup = p; sec = c; ns_ok = n;
        @(negedge clk);
        wr_en = 1'b0;
        err_seen = werr;
        @(negedge clk);
        err_after = werr;
    endtask

    task automatic do_read(input logic s, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; sel = s;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic w_access(input logic w, input logic s, input logic [31:0] d,
                            output logic [31:0] r);
        @(negedge clk);
        w_wr_en = w; w_rd_en = !w; w_sel = s; w_wdata = d;
        @(negedge clk);
        w_wr_en = 1'b0; w_rd_en = 1'b0;
        r = w_rdata;
    endtask

    task automatic probe(input logic [31:0] a);
        logic e;
        taddr = a;
        #1;
        e = (a >= exp_lo) && (a <= exp_hi);
        chk("R8 hit", {31'b0, hit}, {31'b0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [31:0] r, held;
        logic e1, e2, acc;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_lo = 32'h0000_0000;
        exp_hi = 32'h0000_03FF;

        chk("R7 werr idle after reset", {31'b0, werr}, 32'h0);
        do_read(1'b0, r); chk("R1 low reset", r, 32'h0000_0000);
        do_read(1'b1, r); chk("R1 high reset", r, 32'h0000_03FF);
        @(negedge clk);
        probe(32'h0); probe(32'h3FF); probe(32'h400);

        for (int n = 0; n < 2; n++) begin
            for (int p = 0; p < 2; p++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int s = 0; s < 2; s++) begin
                        int k;
                        logic [31:0] d;
                        k = n * 8 + p * 4 + c * 2 + s;
                        d = (s == 0) ? (32'h0010_0000 * (k + 1) + 32'h155)
                                     : (32'h8000_0000 + 32'h0010_0000 * (k + 1) + 32'h2AA);
                        acc = (p == 1) && ((n == 1) || (c == 1));
                        do_read(1'b0, held);
                        do_write(s[0], d, p[0], c[0], n[0], e1, e2);
                        chk("R9 rdata holds without read", rdata, held);
                        if (p == 0)
                            chk("R2 user werr", {31'b0, e1}, 32'h1);
                        else if (n == 0)
                            chk("R3 secure-only werr", {31'b0, e1}, {31'b0, !acc});
                        else
                            chk("R4 ns supervisor werr", {31'b0, e1}, 32'h0);
                        chk("R7 werr one cycle", {31'b0, e2}, 32'h0);
                        if (acc) begin
                            if (s == 0) exp_lo = d & ~32'h3FF;
                            else        exp_hi = d | 32'h3FF;
                        end
                        do_read(1'b0, r); chk("R5 low read / R2 R3 R4 effect", r, exp_lo);
                        do_read(1'b1, r); chk("R6 high read / R2 R3 R4 effect", r, exp_hi);
                        @(negedge clk);
                        probe(exp_lo - 1); probe(exp_lo); probe(exp_lo + 32'h200);
                        probe(exp_hi); probe(exp_hi + 1);
                    end
                end
            end
        end

        w_access(1'b0, 1'b1, 32'h0, r); chk("R10 R1 wide high reset", r, 32'h0000_FFFF);
        w_access(1'b1, 1'b0, 32'h1234_5678, r);
        chk("R10 wide werr", {31'b0, w_werr}, 32'h0);
        w_access(1'b1, 1'b1, 32'h2345_6789, r);
        w_access(1'b0, 1'b0, 32'h0, r); chk("R10 wide low read", r, 32'h1234_0000);
        w_access(1'b0, 1'b1, 32'h0, r); chk("R10 wide high read", r, 32'h2345_FFFF);
        w_taddr = 32'h1233_FFFF; #1; chk("R10 wide below", {31'b0, w_hit}, 32'h0);
        w_taddr = 32'h1234_0000; #1; chk("R10 wide low edge", {31'b0, w_hit}, 32'h1);
        w_taddr = 32'h2345_FFFF; #1; chk("R10 wide high edge", {31'b0, w_hit}, 32'h1);
        w_taddr = 32'h2346_0000; #1; chk("R10 wide above", {31'b0, w_hit}, 32'h0);

        summary();
    end

endmodule